// File: doc/BRIEF.md
# Class-Bounded Dual-Issue Dispatcher

This block decides, in a single cycle, which instructions a throughput core sends to its execution slots. Sixteen warps are split into four fixed groups of four, and each group has its own selector that picks one ready warp per cycle in round-robin order. From the picked warp, the oldest head instruction is a candidate. Its successor is a candidate too when it is marked independent, but only if the oldest one is issued. Four selectors and two instructions each give up to eight candidates per cycle.

The candidates compete for a fixed slot mix: six general ALU slots, one special-function slot and one load/store slot. Grants go in a fixed priority order, and any candidate whose class has no free slot stays where it is. When the class mix of the candidates does not match the slot mix, only part of them issue. For each warp the block reports how many of its head instructions were consumed (0, 1 or 2), so the surrounding pipeline can advance its per-warp instruction pointers. The round-robin state is the only storage. Issue decisions and counts are combinational from the inputs and that state, and the round-robin state updates on the next rising clock edge.

The issue outputs carry no ready input. A slot that is not granted simply sees valid low. Back-pressure is expressed through the inputs: a warp that cannot accept issue is presented with its ready flag low.

Top module: `dsp_issue_top`

## Requirements
- R1: After reset each selector first considers the lowest-numbered warp of its group. While no warp is ready, every slot valid is low, every slot warp ID is 0 and every consume count is 0.
- R2: Selector s considers only warps 4s to 4s+3. It picks the first ready warp found by scanning upward from the warp after the one it last picked, wrapping within the group.
- R3: A selector's last-picked warp becomes the warp it picked this cycle, even when none of that warp's instructions issued. If no warp of the group is ready, the pointer is kept.
- R4: The unit class of a head instruction is encoded in 2 bits: 00 is ALU, 01 is special function, and 1x (10 or 11) is load/store. The oldest instruction of a picked warp issues when a slot of its class is still free.
- R5: The second instruction of a picked warp is a candidate only when its valid and independence flags are both 1 and the warp's oldest instruction issues in the same cycle.
- R6: Candidates are granted in this order: selector 0 oldest, selector 0 second, selector 1 oldest, and so on up to selector 3 second. A denied candidate does not stop later candidates of other classes from issuing.
- R7: ALU grants fill ALU slots 0 upward in grant order. Each valid slot carries the 4-bit ID of the issuing warp, and an unused slot shows ID 0.
- R8: No more than six ALU, one special-function and one load/store instruction issue per cycle. Candidates beyond that are not issued.
- R9: Each warp's consume count equals the number of its instructions issued this cycle. Only a picked warp can have a nonzero count, and the counts over all warps add up to the number of valid slots.
- R10: A warp whose ready flag is low is never picked, never appears on a slot and has a consume count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | 16 | Per-warp ready flag, bit w for warp w |
| head0_cls | input | 16x2 | Unit class of each warp's oldest head instruction |
| head1_valid | input | 16 | Per-warp: a second head instruction exists |
| head1_indep | input | 16 | Per-warp: second instruction is independent of the first |
| head1_cls | input | 16x2 | Unit class of each warp's second head instruction |
| alu_vld | output | 6 | Per ALU slot issue valid |
| alu_wid | output | 6x4 | Warp ID per ALU slot |
| sfu_vld | output | 1 | Special-function slot issue valid |
| sfu_wid | output | 4 | Warp ID on the special-function slot |
| mem_vld | output | 1 | Load/store slot issue valid |
| mem_wid | output | 4 | Warp ID on the load/store slot |
| consume_cnt | output | 16x2 | Per-warp number of head instructions issued (0 to 2) |

## Verification
The assertions assume that reset is held for at least one clock edge and that all inputs are settled before each rising edge. They place no condition on the class codes or the flag combinations, because every 2-bit class value and every pairing of the valid and independence flags is legal. The round-robin check also assumes that, in the cycle it looks at, all four warps of a group are ready. The stimulus drives all inputs only at the falling edge. It uses directed all-ready patterns that trigger that check, together with pseudo-random dense and sparse ready patterns that cover every class code and flag combination.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  typedef enum logic [1:0] {
    K_ALU = 2'd0,
    K_SFU = 2'd1,
    K_MEM = 2'd2
  } unit_kind_e;

  // 00 ALU, 01 special function, 1x load/store
  function automatic unit_kind_e decode_cls(input logic [1:0] c);
    if (c[1])      return K_MEM;
    else if (c[0]) return K_SFU;
    else           return K_ALU;
  endfunction
endpackage

// File: rtl/dsp_warp_picker.sv
module dsp_warp_picker #(
  parameter int GROUP  = 4,
  parameter int LIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUP-1:0]  ready,
  output logic              pick_vld,
  output logic [LIDX_W-1:0] pick_idx
);
  logic [LIDX_W-1:0] last_q;

  // scan starts one past the last pick and wraps inside the group
  always_comb begin
    int c;
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int off = 1; off <= GROUP; off++) begin
      c = (int'(last_q) + off) % GROUP;
      if (!pick_vld && ready[c]) begin
        pick_vld = 1'b1;
        pick_idx = LIDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= LIDX_W'(GROUP - 1);
    else if (pick_vld) last_q <= pick_idx;
  end
endmodule

// File: rtl/dsp_slot_alloc.sv
module dsp_slot_alloc
  import dsp_pkg::*;
#(
  parameter int NSEL  = 4,
  parameter int WID_W = 4,
  parameter int ALU_N = 6
) (
  input  logic       [NSEL-1:0]             sel_vld,
  input  logic       [NSEL-1:0][WID_W-1:0]  sel_wid,
  input  unit_kind_e [NSEL-1:0]             kind0,
  input  unit_kind_e [NSEL-1:0]             kind1,
  input  logic       [NSEL-1:0]             pair_ok,
  output logic       [NSEL-1:0]             take0,
  output logic       [NSEL-1:0]             take1,
  output logic       [ALU_N-1:0]            alu_vld,
  output logic       [ALU_N-1:0][WID_W-1:0] alu_wid,
  output logic                              sfu_vld,
  output logic       [WID_W-1:0]            sfu_wid,
  output logic                              mem_vld,
  output logic       [WID_W-1:0]            mem_wid
);
  localparam int CNT_W = $clog2(ALU_N + 1);

  // grant order: selector index first, then oldest before second
  always_comb begin
    logic [CNT_W-1:0] alu_used;
    logic             want;
    logic             grant;
    unit_kind_e       k;
    take0    = '0;
    take1    = '0;
    alu_vld  = '0;
    alu_wid  = '0;
    sfu_vld  = 1'b0;
    sfu_wid  = '0;
    mem_vld  = 1'b0;
    mem_wid  = '0;
    alu_used = '0;
    for (int s = 0; s < NSEL; s++) begin
      for (int j = 0; j < 2; j++) begin
        want  = (j == 0) ? sel_vld[s] : (take0[s] & pair_ok[s]);
        k     = (j == 0) ? kind0[s] : kind1[s];
        grant = 1'b0;
        if (want) begin
          case (k)
            K_ALU: if (alu_used < CNT_W'(ALU_N)) begin
              alu_vld[alu_used] = 1'b1;
              alu_wid[alu_used] = sel_wid[s];
              alu_used          = alu_used + 1'b1;
              grant             = 1'b1;
            end
            K_SFU: if (!sfu_vld) begin
              sfu_vld = 1'b1;
              sfu_wid = sel_wid[s];
              grant   = 1'b1;
            end
            default: if (!mem_vld) begin
              mem_vld = 1'b1;
              mem_wid = sel_wid[s];
              grant   = 1'b1;
            end
          endcase
        end
        if (j == 0) take0[s] = grant;
        else        take1[s] = grant;
      end
    end
  end
endmodule

// File: rtl/dsp_issue_top.sv
module dsp_issue_top
  import dsp_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int NUM_SEL   = 4,
  parameter int ALU_SLOTS = 6,
  parameter int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_WARPS-1:0]                warp_ready,
  input  logic [NUM_WARPS-1:0][1:0]           head0_cls,
  input  logic [NUM_WARPS-1:0]                head1_valid,
  input  logic [NUM_WARPS-1:0]                head1_indep,
  input  logic [NUM_WARPS-1:0][1:0]           head1_cls,
  output logic [ALU_SLOTS-1:0]                alu_vld,
  output logic [ALU_SLOTS-1:0][WID_W-1:0]     alu_wid,
  output logic                                sfu_vld,
  output logic [WID_W-1:0]                    sfu_wid,
  output logic                                mem_vld,
  output logic [WID_W-1:0]                    mem_wid,
  output logic [NUM_WARPS-1:0][1:0]           consume_cnt
);
  localparam int GROUP  = NUM_WARPS / NUM_SEL;
  localparam int LIDX_W = $clog2(GROUP);

  logic       [NUM_SEL-1:0]             pk_vld;
  logic       [NUM_SEL-1:0][LIDX_W-1:0] pk_idx;
  logic       [NUM_SEL-1:0][WID_W-1:0]  sel_wid;
  unit_kind_e [NUM_SEL-1:0]             k0;
  unit_kind_e [NUM_SEL-1:0]             k1;
  logic       [NUM_SEL-1:0]             pair_ok;
  logic       [NUM_SEL-1:0]             take0;
  logic       [NUM_SEL-1:0]             take1;

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    dsp_warp_picker #(.GROUP(GROUP), .LIDX_W(LIDX_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready   (warp_ready[s*GROUP +: GROUP]),
      .pick_vld(pk_vld[s]),
      .pick_idx(pk_idx[s])
    );
    assign sel_wid[s] = WID_W'(s * GROUP + int'(pk_idx[s]));
    assign k0[s]      = decode_cls(head0_cls[sel_wid[s]]);
    assign k1[s]      = decode_cls(head1_cls[sel_wid[s]]);
    assign pair_ok[s] = head1_valid[sel_wid[s]] & head1_indep[sel_wid[s]];
  end

  dsp_slot_alloc #(.NSEL(NUM_SEL), .WID_W(WID_W), .ALU_N(ALU_SLOTS)) u_alloc (
    .sel_vld(pk_vld),
    .sel_wid(sel_wid),
    .kind0  (k0),
    .kind1  (k1),
    .pair_ok(pair_ok),
    .take0  (take0),
    .take1  (take1),
    .alu_vld(alu_vld),
    .alu_wid(alu_wid),
    .sfu_vld(sfu_vld),
    .sfu_wid(sfu_wid),
    .mem_vld(mem_vld),
    .mem_wid(mem_wid)
  );

  // a second grant always implies the first, so the count is {take1, take0 & ~take1}
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_cnt
    localparam int SI = w / GROUP;
    localparam int LI = w % GROUP;
    assign consume_cnt[w] = (pk_vld[SI] && pk_idx[SI] == LIDX_W'(LI)) ?
                            {take1[SI], take0[SI] & ~take1[SI]} : 2'b00;
  end
endmodule

// File: rtl/dsp_issue_chk.sv
module dsp_issue_chk #(
  parameter int NUM_WARPS = 16,
  parameter int NUM_SEL   = 4,
  parameter int ALU_SLOTS = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_WARPS-1:0]      warp_ready,
  input logic [NUM_WARPS-1:0]      head1_valid,
  input logic [NUM_WARPS-1:0]      head1_indep,
  input logic [ALU_SLOTS-1:0]      alu_vld,
  input logic                      sfu_vld,
  input logic                      mem_vld,
  input logic [NUM_WARPS-1:0][1:0] consume_cnt
);
  localparam int GROUP = NUM_WARPS / NUM_SEL;

  logic seen;
  int   cons_sum;
  int   vld_sum;
  logic [NUM_WARPS-1:0] busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_comb begin
    cons_sum = 0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      cons_sum += int'(consume_cnt[w]);
      busy[w]   = |consume_cnt[w];
    end
    vld_sum = $countones(alu_vld) + int'(sfu_vld) + int'(mem_vld);
  end

  assert_count_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cons_sum == vld_sum);

  for (genvar a = 0; a + 1 < ALU_SLOTS; a++) begin : g_alu
    assert_alu_packed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      alu_vld[a+1] |-> alu_vld[a]);
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_grp
    assert_one_warp_per_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy[g*GROUP +: GROUP]));
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    localparam int G = w / GROUP;
    assert_idle_no_consume_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !warp_ready[w] |-> consume_cnt[w] == 2'd0);
    assert_pair_needs_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      consume_cnt[w] == 2'd2 |-> (head1_valid[w] && head1_indep[w]));
    assert_rr_moves_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(consume_cnt[w] != 2'd0) && (&warp_ready[G*GROUP +: GROUP]))
      |-> consume_cnt[w] == 2'd0);
  end
endmodule

bind dsp_issue_top dsp_issue_chk #(
  .NUM_WARPS(NUM_WARPS),
  .NUM_SEL  (NUM_SEL),
  .ALU_SLOTS(ALU_SLOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .warp_ready (warp_ready),
  .head1_valid(head1_valid),
  .head1_indep(head1_indep),
  .alu_vld    (alu_vld),
  .sfu_vld    (sfu_vld),
  .mem_vld    (mem_vld),
  .consume_cnt(consume_cnt)
);

// File: tb/sim_dsp_issue_top.sv
`timescale 1ns/1ps
module sim_dsp_issue_top;
  localparam int NW = 16;
  localparam int NS = 4;
  localparam int NA = 6;
  localparam int G  = NW / NS;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NW-1:0]         warp_ready = '0;
  logic [NW-1:0][1:0]    head0_cls = '0;
  logic [NW-1:0]         head1_valid = '0;
  logic [NW-1:0]         head1_indep = '0;
  logic [NW-1:0][1:0]    head1_cls = '0;
  logic [NA-1:0]         alu_vld;
  logic [NA-1:0][3:0]    alu_wid;
  logic                  sfu_vld;
  logic [3:0]            sfu_wid;
  logic                  mem_vld;
  logic [3:0]            mem_wid;
  logic [NW-1:0][1:0]    consume_cnt;

  dsp_issue_top u0 (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .head0_cls(head0_cls),
    .head1_valid(head1_valid), .head1_indep(head1_indep), .head1_cls(head1_cls),
    .alu_vld(alu_vld), .alu_wid(alu_wid), .sfu_vld(sfu_vld), .sfu_wid(sfu_wid),
    .mem_vld(mem_vld), .mem_wid(mem_wid), .consume_cnt(consume_cnt)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int ptr_m [NS];
  int nxt_m [NS];
  logic [NA-1:0]      e_alu_vld;
  logic [NA-1:0][3:0] e_alu_wid;
  logic               e_sfu_vld, e_mem_vld;
  logic [3:0]         e_sfu_wid, e_mem_wid;
  logic [NW-1:0][1:0] e_cons;
  logic [31:0]        rng = 32'h1234_5678;

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // reference from the requirements: round-robin per group, ordered grants
  task automatic model();
    int  alu_n;
    int  ch;
    int  w;
    int  l;
    bit  got0;
    bit  ok;
    logic [1:0] c;
    alu_n = 0;
    e_alu_vld = '0; e_alu_wid = '0;
    e_sfu_vld = 1'b0; e_sfu_wid = '0;
    e_mem_vld = 1'b0; e_mem_wid = '0;
    e_cons = '0;
    for (int s = 0; s < NS; s++) begin
      ch = -1;
      for (int off = 1; off <= G; off++) begin
        l = (ptr_m[s] + off) % G;
        if (ch < 0 && warp_ready[s*G + l]) ch = l;
      end
      nxt_m[s] = (ch >= 0) ? ch : ptr_m[s];
      if (ch >= 0) begin
        w = s*G + ch;
        got0 = 1'b0;
        for (int j = 0; j < 2; j++) begin
          if (j == 0 || (got0 && head1_valid[w] && head1_indep[w])) begin
            c = (j == 0) ? head0_cls[w] : head1_cls[w];
            ok = 1'b0;
            if (c[1]) begin
              if (!e_mem_vld) begin e_mem_vld = 1'b1; e_mem_wid = 4'(w); ok = 1'b1; end
            end else if (c[0]) begin
              if (!e_sfu_vld) begin e_sfu_vld = 1'b1; e_sfu_wid = 4'(w); ok = 1'b1; end
            end else if (alu_n < NA) begin
              e_alu_vld[alu_n] = 1'b1; e_alu_wid[alu_n] = 4'(w); alu_n++; ok = 1'b1;
            end
            if (ok) e_cons[w] = e_cons[w] + 2'd1;
            if (j == 0) got0 = ok;
          end
        end
      end
    end
  endtask

  task automatic compare_all();
    check_eq("R7 alu valid", 64'(alu_vld), 64'(e_alu_vld));
    check_eq("R7 alu warp ids", 64'(alu_wid), 64'(e_alu_wid));
    check_eq("R8 R4 sfu slot", {59'd0, sfu_vld, sfu_wid}, {59'd0, e_sfu_vld, e_sfu_wid});
    check_eq("R8 R4 mem slot", {59'd0, mem_vld, mem_wid}, {59'd0, e_mem_vld, e_mem_wid});
    check_eq("R2 R9 consume", 64'(consume_cnt), 64'(e_cons));
  endtask

  task automatic step(input logic [NW-1:0] rdy, input logic [NW-1:0][1:0] c0,
                      input logic [NW-1:0] v1, input logic [NW-1:0] i1,
                      input logic [NW-1:0][1:0] c1);
    @(negedge clk);
    warp_ready = rdy; head0_cls = c0; head1_valid = v1; head1_indep = i1; head1_cls = c1;
    #1;
    model();
    compare_all();
    for (int s = 0; s < NS; s++) ptr_m[s] = nxt_m[s];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NW-1:0][1:0] sfu_all;
    logic [31:0] r1, r2, r3;
    for (int s = 0; s < NS; s++) ptr_m[s] = G - 1;
    for (int w = 0; w < NW; w++) sfu_all[w] = 2'b01;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state with nothing ready
    check_eq("R1 reset alu", 64'(alu_vld), 64'd0);
    check_eq("R1 reset ids", 64'(alu_wid), 64'd0);
    check_eq("R1 reset sfu mem", {62'd0, sfu_vld, mem_vld}, 64'd0);
    check_eq("R1 reset consume", 64'(consume_cnt), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 R8: eight ALU candidates against six slots
    step('1, '0, '1, '1, '0);
    check_eq("R6 alu order", 64'(alu_wid), 64'h88_4400);
    check_eq("R8 warp12 denied", 64'(consume_cnt[12]), 64'd0);
    check_eq("R6 warp0 two", 64'(consume_cnt[0]), 64'd2);
    // R3: warp 12 got nothing yet the pointer moved past it
    step('1, '0, '1, '1, '0);
    check_eq("R3 rr advance ids", 64'(alu_wid), 64'h99_5511);
    check_eq("R3 warp13 skipped", 64'(consume_cnt[13]), 64'd0);
    // R4 R5: all oldest are special function, second is ALU
    step('1, sfu_all, '1, '1, '0);
    check_eq("R4 sfu winner", {60'd0, sfu_wid}, 64'd2);
    check_eq("R5 pair follows first", 64'(consume_cnt[2]), 64'd2);
    check_eq("R5 blocked pair", 64'(consume_cnt[6]), 64'd0);
    check_eq("R5 alu single", 64'(alu_vld), 64'd1);
    // R5: independence flag clear stops the pair
    step('1, '0, '1, '0, '0);
    check_eq("R5 indep clear", 64'(consume_cnt[3]), 64'd1);
    // R10: group 1 idle
    step(16'hFF0F, '0, '1, '1, '0);
    check_eq("R10 idle group", 64'(consume_cnt[7:4]), 64'd0);
    // R1 R10: nothing ready after running
    step('0, '0, '1, '1, '0);
    check_eq("R10 none ready", 64'(alu_vld), 64'd0);

    // near-exhaustive pseudo-random sweep, dense then sparse ready
    for (int n = 0; n < 6000; n++) begin
      rng = next_rand(rng); r1 = rng;
      rng = next_rand(rng); r2 = rng;
      rng = next_rand(rng); r3 = rng;
      step((n < 3000) ? (r1[15:0] | r1[31:16]) : (r1[15:0] & r1[31:16]),
           r2, r3[15:0], r3[31:16], r2 ^ r3);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule